// File: doc/BRIEF.md
# Floating-Point Result Rounding Stage

This block is the last step of a single-precision arithmetic datapath. An upstream unit delivers a value that is not yet rounded: a sign, a biased exponent, a normalized 24-bit significand with the hidden one in its top bit, and three bits that describe what lies below the last kept bit. These three bits are the guard bit, which is the first bit below the kept part. The round bit is the next bit down. The sticky bit is the OR of every bit below the round bit. A 2-bit mode input selects the rounding direction.

The block rounds the significand in one clocked stage. When rounding carries past the top of the significand, it renormalizes. It then packs a 32-bit single-precision word and raises an inexact flag and an overflow flag. An input exponent of all ones means that the upstream value is already out of range. Such a value goes through the same overflow handling as a value that overflows because of rounding. The block does not produce denormal outputs.

Top module: `fp_round_unit`

## Requirements
- R1: Mode code 00 selects round-to-nearest. In that mode, the kept significand is unchanged when guard is 0, and it is incremented by one ULP when guard is 1 and round or sticky is 1.
- R2: In mode 00, when guard is 1 and both round and sticky are 0 (an exact half), the result is incremented only if the kept least significant bit is 1, so that bit ends at 0.
- R3: Mode code 01 (toward zero) never increments. With an exponent below all ones, the output word is {sign, exponent, significand bits 22..0} of the input.
- R4: Mode code 10 (toward plus infinity) increments only when the sign is 0 and at least one of guard, round or sticky is 1. Negative values are truncated.
- R5: Mode code 11 (toward minus infinity) increments only when the sign is 1 and at least one of guard, round or sticky is 1. Positive values are truncated.
- R6: If the increment carries out of the 24-bit significand, the stored fraction becomes all zeros and the exponent field becomes the input exponent plus one.
- R7: When the final exponent reaches 255, out_overflow is 1. In mode 00, and in any directed mode that points the same way as the sign, the word is infinity with the input sign (exponent field 8'hFF, fraction 0).
- R8: On overflow in mode 01, in mode 10 with sign 1, and in mode 11 with sign 0, the word is the largest finite magnitude with the input sign (exponent field 8'hFE, fraction 23'h7FFFFF).
- R9: out_inexact is 1 when guard, round or sticky is nonzero, or when overflow occurs. Otherwise it is 0.
- R10: An input with guard, round and sticky all 0 and an exponent below all ones gives the packed input unchanged in every mode, with both flags 0.
- R11: Results appear one clock after in_valid is sampled high, with out_valid high for exactly that cycle. A synchronous active-low reset clears out_valid, out_word and both flags. Outputs hold between valid inputs.
- R12: Bit 31 of out_word always equals the input sign of the value that produced it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input value is present this cycle |
| in_sign | input | 1 | Sign of the unrounded value |
| in_exp | input | 8 | Biased exponent; all ones means out of range |
| in_sig | input | 24 | Normalized significand, bit 23 is the hidden one |
| in_guard | input | 1 | First discarded bit (half ULP) |
| in_round | input | 1 | Second discarded bit |
| in_sticky | input | 1 | OR of all lower discarded bits |
| in_mode | input | 2 | 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| out_valid | output | 1 | Rounded result is present |
| out_word | output | 32 | Packed single-precision result |
| out_inexact | output | 1 | Result differs from the exact value |
| out_overflow | output | 1 | Result exceeded the finite range |

## Verification
The stage holds state only in its output register. A wrong rounding decision therefore shows as a fraction that is off by one ULP in the cycle after the input. A lost carry shows in that same cycle as a fraction that wraps to zero while the exponent stays unchanged. The largest risk lies in the boundaries. These are exact halves with an odd or even last bit, an all-ones significand at exponent 254, and the overflow result in each mode and sign combination. These boundaries are covered with directed cases. Random values weighted toward them cover the remaining combinations, and each one is compared in the next cycle with a reference model.

// File: rtl/fpr_pkg.sv
// Shared types for the rounding stage.
// Assumes the single-precision layout (1 sign, 8 exponent, 23 fraction bits)
// as default, but all widths are carried as parameters in the modules.
package fpr_pkg;

    // Rounding direction; the code values are visible at the in_mode port.
    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'b00,
        RM_TO_ZERO   = 2'b01,
        RM_TO_POS    = 2'b10,
        RM_TO_NEG    = 2'b11
    } rmode_e;

    // Whether an overflow in this mode with this sign saturates to infinity.
    function automatic logic ovf_to_infinity(input rmode_e mode, input logic sign);
        logic r;
        case (mode)
            RM_NEAR_EVEN: r = 1'b1;
            RM_TO_ZERO:   r = 1'b0;
            RM_TO_POS:    r = ~sign;
            default:      r = sign;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fpr_decide.sv
// Rounding decision.
// Works out from the discarded bits, the kept LSB, the sign and the mode
// whether one ULP must be added. Purely combinational.
// Assumes: guard is the half-ULP bit, round is next, and sticky is the OR of the rest.
module fpr_decide
    import fpr_pkg::*;
(
    input  rmode_e mode,
    input  logic   sign,
    input  logic   kept_lsb,
    input  logic   guard,
    input  logic   round,
    input  logic   sticky,
    output logic   inc,
    output logic   discarded_nz
);
    logic below_half_nz;

    // Gather the discarded bits into "anything below the guard" and "anything at all".
    always_comb begin
        below_half_nz = round | sticky;
        discarded_nz  = guard | below_half_nz;
    end

    // Pick the increment per mode; in nearest mode an exact half breaks to even.
    always_comb begin
        case (mode)
            RM_NEAR_EVEN: inc = guard & (below_half_nz | kept_lsb);
            RM_TO_ZERO:   inc = 1'b0;
            RM_TO_POS:    inc = ~sign & discarded_nz;
            default:      inc = sign & discarded_nz;
        endcase
    end
endmodule

// File: rtl/fpr_increment.sv
// Significand increment with renormalization.
// Adds the rounding increment to the SIG_W-bit significand. On carry-out it
// shifts right one place and bumps the exponent. Flags when the exponent has
// reached all ones, which includes an input that already carries all ones.
// Assumes: the input significand is normalized (top bit set).
module fpr_increment #(
    parameter int SIG_W = 24,
    parameter int EXP_W = 8
) (
    input  logic [SIG_W-1:0] sig_in,
    input  logic [EXP_W-1:0] exp_in,
    input  logic             inc,
    output logic [SIG_W-1:0] sig_out,
    output logic [EXP_W-1:0] exp_out,
    output logic             exp_sat
);
    localparam logic [EXP_W:0] EXP_LIMIT = {1'b0, {EXP_W{1'b1}}};

    logic [SIG_W:0]   sum;
    logic [EXP_W:0]   exp_wide;
    logic             carry;

    // Add the increment with one spare bit to catch the carry.
    always_comb begin
        sum   = {1'b0, sig_in} + {{SIG_W{1'b0}}, inc};
        carry = sum[SIG_W];
    end

    // Renormalize on carry: take the upper bits and move the exponent up one.
    always_comb begin
        if (carry) begin
            sig_out  = sum[SIG_W:1];
            exp_wide = {1'b0, exp_in} + {{EXP_W{1'b0}}, 1'b1};
        end else begin
            sig_out  = sum[SIG_W-1:0];
            exp_wide = {1'b0, exp_in};
        end
    end

    // Saturation check: anything at or beyond all ones cannot be encoded as finite.
    always_comb begin
        exp_sat = (exp_wide >= EXP_LIMIT);
        exp_out = exp_wide[EXP_W-1:0];
    end
endmodule

// File: rtl/fpr_pack.sv
// Result packing and overflow handling.
// Builds the output word from the rounded fields. On exponent saturation it
// returns infinity or the largest finite magnitude, chosen by mode and sign.
// Assumes: sig_in has its hidden bit at the top, and that bit is dropped here.
module fpr_pack
    import fpr_pkg::*;
#(
    parameter int SIG_W = 24,
    parameter int EXP_W = 8
) (
    input  rmode_e           mode,
    input  logic             sign,
    input  logic [EXP_W-1:0] exp_in,
    input  logic [SIG_W-1:0] sig_in,
    input  logic             exp_sat,
    output logic [EXP_W+SIG_W-1:0] word,
    output logic             overflow
);
    localparam int MAN_W = SIG_W - 1;
    localparam logic [EXP_W-1:0] EXP_ONES = {EXP_W{1'b1}};
    localparam logic [EXP_W-1:0] EXP_MAXF = {{(EXP_W-1){1'b1}}, 1'b0};

    logic [EXP_W-1:0] exp_field;
    logic [MAN_W-1:0] man_field;

    // Select the exponent and fraction fields for the finite and saturated cases.
    always_comb begin
        overflow = exp_sat;
        if (!exp_sat) begin
            exp_field = exp_in;
            man_field = sig_in[MAN_W-1:0];
        end else if (ovf_to_infinity(mode, sign)) begin
            exp_field = EXP_ONES;
            man_field = '0;
        end else begin
            exp_field = EXP_MAXF;
            man_field = '1;
        end
    end

    // Concatenate sign, exponent and fraction.
    always_comb begin
        word = {sign, exp_field, man_field};
    end
endmodule

// File: rtl/fp_round_unit.sv
// Single-precision rounding stage, top level.
// Takes a normalized unrounded value with guard, round and sticky bits and a
// rounding mode. One clock later it presents the rounded packed word with
// inexact and overflow flags.
// Assumes: in_sig is normalized. An in_exp of all ones marks a value that is
// already out of range. No denormal results are produced.
module fp_round_unit
    import fpr_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   in_sign,
    input  logic [EXP_W-1:0]       in_exp,
    input  logic [MAN_W:0]         in_sig,
    input  logic                   in_guard,
    input  logic                   in_round,
    input  logic                   in_sticky,
    input  logic [1:0]             in_mode,
    output logic                   out_valid,
    output logic [EXP_W+MAN_W:0]   out_word,
    output logic                   out_inexact,
    output logic                   out_overflow
);
    localparam int SIG_W  = MAN_W + 1;
    localparam int WORD_W = 1 + EXP_W + MAN_W;

    rmode_e              mode;
    logic                inc;
    logic                discarded_nz;
    logic [SIG_W-1:0]    sig_rnd;
    logic [EXP_W-1:0]    exp_rnd;
    logic                exp_sat;
    logic [WORD_W-1:0]   word_nxt;
    logic                ovf_nxt;
    logic                inexact_nxt;

    // Interpret the raw mode bits as the rounding-direction type.
    always_comb begin
        mode = rmode_e'(in_mode);
    end

    fpr_decide u_decide (
        .mode         (mode),
        .sign         (in_sign),
        .kept_lsb     (in_sig[0]),
        .guard        (in_guard),
        .round        (in_round),
        .sticky       (in_sticky),
        .inc          (inc),
        .discarded_nz (discarded_nz)
    );

    fpr_increment #(
        .SIG_W (SIG_W),
        .EXP_W (EXP_W)
    ) u_increment (
        .sig_in  (in_sig),
        .exp_in  (in_exp),
        .inc     (inc),
        .sig_out (sig_rnd),
        .exp_out (exp_rnd),
        .exp_sat (exp_sat)
    );

    fpr_pack #(
        .SIG_W (SIG_W),
        .EXP_W (EXP_W)
    ) u_pack (
        .mode     (mode),
        .sign     (in_sign),
        .exp_in   (exp_rnd),
        .sig_in   (sig_rnd),
        .exp_sat  (exp_sat),
        .word     (word_nxt),
        .overflow (ovf_nxt)
    );

    // An overflowed result is never exact, so overflow also sets inexact.
    always_comb begin
        inexact_nxt = discarded_nz | ovf_nxt;
    end

    // Output register: capture on valid input, hold otherwise, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_word     <= '0;
            out_inexact  <= 1'b0;
            out_overflow <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_word     <= word_nxt;
                out_inexact  <= inexact_nxt;
                out_overflow <= ovf_nxt;
            end
        end
    end
endmodule

// File: rtl/fp_round_unit_checker.sv
// Temporal checks for fp_round_unit, bound to every instance of it.
// Assumes the top's port names. All properties are disabled during reset.
module fp_round_unit_checker #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 in_sign,
    input logic [EXP_W-1:0]     in_exp,
    input logic [MAN_W:0]       in_sig,
    input logic                 in_guard,
    input logic                 in_round,
    input logic                 in_sticky,
    input logic [1:0]           in_mode,
    input logic                 out_valid,
    input logic [EXP_W+MAN_W:0] out_word,
    input logic                 out_inexact,
    input logic                 out_overflow
);
    localparam logic [EXP_W-1:0] EXP_ONES = {EXP_W{1'b1}};
    localparam logic [EXP_W-1:0] EXP_MAXF = {{(EXP_W-1){1'b1}}, 1'b0};

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R11
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(out_word)); // R11
    AST_INEXACT_SET: assert property (@(posedge clk) disable iff (!rst_n) in_valid && (in_guard || in_round || in_sticky) |=> out_inexact); // R9
    AST_EXACT_PASS: assert property (@(posedge clk) disable iff (!rst_n) in_valid && !(in_guard || in_round || in_sticky) && in_exp != EXP_ONES |=> out_word == $past({in_sign, in_exp, in_sig[MAN_W-1:0]}) && !out_inexact && !out_overflow); // R10
    AST_TOWARD_ZERO_TRUNC: assert property (@(posedge clk) disable iff (!rst_n) in_valid && in_mode == 2'b01 && in_exp != EXP_ONES |=> out_word == $past({in_sign, in_exp, in_sig[MAN_W-1:0]})); // R3
    AST_OVF_INEXACT: assert property (@(posedge clk) disable iff (!rst_n) out_overflow |-> out_inexact); // R9
    AST_OVF_ENCODING: assert property (@(posedge clk) disable iff (!rst_n) out_valid && out_overflow |-> (out_word[EXP_W+MAN_W-1:MAN_W] == EXP_ONES && out_word[MAN_W-1:0] == '0) || (out_word[EXP_W+MAN_W-1:MAN_W] == EXP_MAXF && &out_word[MAN_W-1:0])); // R8
    AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_word[EXP_W+MAN_W] == $past(in_sign)); // R12
endmodule

bind fp_round_unit fp_round_unit_checker #(.EXP_W(EXP_W), .MAN_W(MAN_W)) chk_i (.*);

// File: tb/fp_round_unit_tb_top.sv
`timescale 1ns/1ps
module fp_round_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sign = 1'b0;
    logic [7:0]  in_exp = '0;
    logic [23:0] in_sig = '0;
    logic        in_guard = 1'b0;
    logic        in_round = 1'b0;
    logic        in_sticky = 1'b0;
    logic [1:0]  in_mode = '0;
    logic        out_valid;
    logic [31:0] out_word;
    logic        out_inexact;
    logic        out_overflow;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    fp_round_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
        .in_exp(in_exp), .in_sig(in_sig), .in_guard(in_guard), .in_round(in_round),
        .in_sticky(in_sticky), .in_mode(in_mode), .out_valid(out_valid),
        .out_word(out_word), .out_inexact(out_inexact), .out_overflow(out_overflow)
    );

    // Reference model: {word, inexact, overflow}
    function automatic logic [33:0] ref_round(input logic sg, input int e, input int sig,
                                              input logic g, input logic r, input logic s,
                                              input logic [1:0] m);
        logic disc, up, ovf, inf;
        int s2, e2;
        logic [31:0] w;
        disc = g | r | s;
        case (m)
            2'b00: up = g && (r || s || sig[0]);
            2'b01: up = 1'b0;
            2'b10: up = !sg && disc;
            default: up = sg && disc;
        endcase
        s2 = sig + int'(up);
        e2 = e;
        if (s2 == (1 << 24)) begin s2 = 1 << 23; e2 = e2 + 1; end
        ovf = (e2 >= 255);
        if (ovf) begin
            inf = (m == 2'b00) || (m == 2'b10 && !sg) || (m == 2'b11 && sg);
            w = inf ? {sg, 8'hFF, 23'h0} : {sg, 8'hFE, 23'h7FFFFF};
        end else begin
            w = {sg, e2[7:0], s2[22:0]};
        end
        return {w, disc | ovf, ovf};
    endfunction

    task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            failures++;
            $display("FAIL %s: actual word=%h inx=%b ovf=%b expected word=%h inx=%b ovf=%b",
                     tag, act[33:2], act[1], act[0], exp_v[33:2], exp_v[1], exp_v[0]);
        end
    endtask

    // Apply one value for one cycle and check the registered result.
    task automatic apply(input string tag, input logic sg, input int e, input int sig,
                         input logic g, input logic r, input logic s, input logic [1:0] m);
        logic [33:0] exp_v;
        in_valid = 1'b1; in_sign = sg; in_exp = e[7:0]; in_sig = sig[23:0];
        in_guard = g; in_round = r; in_sticky = s; in_mode = m;
        exp_v = ref_round(sg, e, sig, g, r, s, m);
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, {out_word, out_inexact, out_overflow}, exp_v);
        checks++;
        if (out_valid !== 1'b1) begin
            failures++;
            $display("FAIL R11: out_valid actual=%b expected=1", out_valid);
        end
    endtask

    function automatic string tag_for(input logic sg, input int e, input int sig,
                                      input logic g, input logic r, input logic s, input logic [1:0] m);
        logic [33:0] v;
        v = ref_round(sg, e, sig, g, r, s, m);
        if (v[0]) return ((m == 2'b00) || (m == 2'b10 && !sg) || (m == 2'b11 && sg)) ? "R7" : "R8";
        if (v[24:2] == 23'h0 && sig == 24'hFFFFFF && v[33:2] != {sg, e[7:0], 23'h0}) return "R6";
        if (!(g | r | s)) return "R10";
        case (m)
            2'b00: return (g && !r && !s) ? "R2" : "R1";
            2'b01: return "R3";
            2'b10: return "R4";
            default: return "R5";
        endcase
    endfunction

    initial begin
        #(4 * 20000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'h5EED_1234);
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", {out_word, out_inexact, out_overflow}, 34'h0);
        checks++;
        if (out_valid !== 1'b0) begin failures++; $display("FAIL R11: out_valid actual=%b expected=0", out_valid); end
        rst_n = 1'b1;
        @(negedge clk);

        apply("R1", 0, 100, 24'h800001, 0, 1, 1, 2'b00);
        apply("R1", 1, 100, 24'h800001, 1, 0, 1, 2'b00);
        apply("R2", 0, 90,  24'h800002, 1, 0, 0, 2'b00);
        apply("R2", 0, 90,  24'h800003, 1, 0, 0, 2'b00);
        apply("R3", 1, 120, 24'hABCDEF, 1, 1, 1, 2'b01);
        apply("R4", 0, 120, 24'hABCDEF, 0, 0, 1, 2'b10);
        apply("R4", 1, 120, 24'hABCDEF, 1, 1, 1, 2'b10);
        apply("R5", 1, 120, 24'hABCDEF, 0, 1, 0, 2'b11);
        apply("R5", 0, 120, 24'hABCDEF, 1, 0, 0, 2'b11);
        apply("R6", 0, 100, 24'hFFFFFF, 1, 0, 1, 2'b00);
        apply("R7", 0, 254, 24'hFFFFFF, 1, 1, 0, 2'b00);
        apply("R7", 1, 254, 24'hFFFFFF, 0, 0, 1, 2'b11);
        apply("R8", 1, 255, 24'h900000, 0, 0, 0, 2'b01);
        apply("R8", 1, 255, 24'h800000, 1, 0, 0, 2'b10);
        apply("R8", 0, 255, 24'hC00000, 0, 1, 0, 2'b11);
        apply("R10", 1, 1,  24'hFFFFFF, 0, 0, 0, 2'b10);
        apply("R10", 0, 254, 24'hFFFFFF, 0, 0, 0, 2'b00);
        apply("R12", 1, 77, 24'h812345, 1, 1, 0, 2'b00);

        // R11: outputs hold while idle
        begin
            logic [31:0] held;
            held = out_word;
            repeat (3) @(negedge clk);
            checks++;
            if (out_word !== held || out_valid !== 1'b0) begin
                failures++;
                $display("FAIL R11: idle word actual=%h expected=%h", out_word, held);
            end
        end

        for (int i = 0; i < 600; i++) begin
            logic sg, g, r, s;
            logic [1:0] m;
            int e, sig;
            sg = 1'($urandom); g = 1'($urandom); r = 1'($urandom); s = 1'($urandom);
            m = 2'($urandom);
            case ($urandom_range(0, 7))
                0: begin e = 254; sig = 24'hFFFFFF; end
                1: begin e = 255; sig = 32'h800000 | 32'($urandom_range(0, 24'h7FFFFF)); end
                2: begin e = int'($urandom_range(1, 253)); sig = 24'hFFFFFF; end
                default: begin e = int'($urandom_range(1, 254)); sig = 32'h800000 | 32'($urandom_range(0, 24'h7FFFFF)); end
            endcase
            apply(tag_for(sg, e, sig, g, r, s, m), sg, e, sig, g, r, s, m);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule